// File: doc/BRIEF.md
# Johnson Decade Divider with One-Hot Decode

This block divides a count signal by ten using a five-stage twisted-ring (Johnson) register. Its state is decoded into ten one-hot lines, so exactly one output is high at any time and the high line moves up by one position on every count step. A carry line provides a symmetric square wave at one tenth of the count rate.

All logic runs on one system clock. The count clock, the active-high count inhibit and the clear input arrive as asynchronous levels. Each passes through a two-flop synchronizer. A count step is taken on each rising edge of the combined level "count clock high and inhibit low". That edge can come from a rising count clock while the inhibit is low, or from a falling inhibit while the count clock is high. The clear input forces the decoded outputs to count 0 at once and clears the register. Any illegal register code is replaced by count 0 on the next step.

Top module: `johnson_decade_div`

## Requirements
- R1: While `rst_n` is low on a clock edge, the register returns to count 0: `dec_o` reads 10'b0000000001 (bit k high means count k) and `carry_o` is high.
- R2: A rising `cnt_clk_i` while `cnt_inhibit_i` is low advances the count by exactly one. The new value appears after the third system clock edge that follows the input change.
- R3: A falling `cnt_inhibit_i` while `cnt_clk_i` is high advances the count by exactly one, with the same three-edge latency.
- R4: The count does not change on a falling `cnt_clk_i`, on a rising `cnt_inhibit_i`, or while `cnt_inhibit_i` is held high, whatever `cnt_clk_i` does.
- R5: `dec_o` always has exactly one bit set. Each step moves it from bit k to bit k+1, and from bit 9 it wraps to bit 0.
- R6: `carry_o` is high for counts 0 to 4 and low for counts 5 to 9, so it rises on the wrap from 9 to 0.
- R7: While `clear_i` is high, `dec_o` is 10'b0000000001 and `carry_o` is high, combinationally and regardless of the other inputs. The register is cleared, and releasing `clear_i` while the combined count level is high does not cause a step.
- R8: From any of the 32 register codes, the next step goes to a legal count. A legal code at count k goes to count k+1 mod 10. Any of the 22 illegal codes goes to count 0.
- R9: A combined count level that stays high causes only one step, however long it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clk_i | input | 1 | Asynchronous count clock level |
| cnt_inhibit_i | input | 1 | Asynchronous count inhibit, high blocks counting |
| clear_i | input | 1 | Asynchronous clear, high forces count 0 |
| dec_o | output | 10 | One-hot decoded count, bit k high at count k |
| carry_o | output | 1 | High for counts 0 to 4 |

## Verification
A count input change crosses two synchronizer flops and the edge detector, so the decoded outputs change after the third system clock edge. The bench waits four edges after every count stimulus and samples at the following falling edge. The clear input is combinational to the outputs, so it is checked one nanosecond after it is driven, and again after it is released once the synchronized clear has flushed through. Illegal-code recovery is swept over all 32 codes: each is forced into the register, and the decoded count is compared after one step.

// File: rtl/jdc_pkg.sv
// Package: shared constants and types for the Johnson decade divider.
// Assumes: STAGES is at least 2; outputs number twice the stage count.
package jdc_pkg;
    parameter int JDC_STAGES = 5;

    // Synchronized control bundle
    typedef struct packed {
        logic cnt_clk;
        logic inhibit;
        logic clear;
    } jdc_ctl_t;

    localparam jdc_ctl_t JDC_CTL_RESET = '{cnt_clk: 1'b0, inhibit: 1'b1, clear: 1'b0};
endpackage

// File: rtl/jdc_sync.sv
// Module: two-flop synchronizer for the control bundle.
// Assumes: inputs are slow levels; each bit is synchronized on its own.
module jdc_sync
    import jdc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  jdc_ctl_t async_i,
    output jdc_ctl_t sync_o
);
    jdc_ctl_t meta_q;
    jdc_ctl_t sync_q;

    // Two register stages, reset to an idle (non-counting) bundle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= JDC_CTL_RESET;
            sync_q <= JDC_CTL_RESET;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/jdc_step_detect.sv
// Module: produces a one-cycle step pulse on a rising edge of
// (count clock AND NOT inhibit). The history flop follows the level
// even during clear, so releasing clear never creates a step.
// Assumes: inputs are already synchronized to clk.
module jdc_step_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_clk_s_i,
    input  logic inhibit_s_i,
    input  logic clear_s_i,
    output logic step_o
);
    logic level;
    logic prev_q;

    assign level = cnt_clk_s_i & ~inhibit_s_i;

    // History of the combined level; reset high so a held level is not counted
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level;
    end

    assign step_o = level & ~prev_q & ~clear_s_i;

    // R9
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R4
    inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_s_i |-> !step_o);
endmodule

// File: rtl/jdc_ring.sv
// Module: twisted-ring state register. On a step it shifts left and
// loads the inverted top bit at the bottom. A code with more than one
// boundary between adjacent bits is illegal and is replaced by zero.
// Assumes: step_i is a single-cycle pulse; clr_i is synchronized.
module jdc_ring #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              clr_i,
    output logic [STAGES-1:0] state_o
);
    localparam int EDGES = STAGES - 1;

    logic [STAGES-1:0] state_q;
    logic [STAGES-1:0] state_d;
    logic [EDGES-1:0]  boundary;
    logic              legal;

    // Adjacent-bit boundaries; a legal code has at most one
    assign boundary = state_q[STAGES-1:1] ^ state_q[STAGES-2:0];
    assign legal    = ($countones(boundary) <= 1);

    // Next-state selection: clear, corrected shift, or hold
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = '0;
        end else if (step_i) begin
            if (legal) state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
            else       state_d = '0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R8
    legal_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i) |=> ($countones(state_q[STAGES-1:1] ^ state_q[STAGES-2:0]) <= 1));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_q == '0));

    // R2
    first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && state_q == '0) |=> (state_q == STAGES'(1)));
endmodule

// File: rtl/jdc_decode.sv
// Module: decodes the twisted-ring state into one-hot count lines and
// the carry. Each line looks at two adjacent bits only. The raw clear
// forces the count-0 pattern without waiting for synchronization.
// Assumes: OUTS equals twice STAGES.
module jdc_decode #(
    parameter int STAGES = 5,
    parameter int OUTS   = 2 * STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] state_i,
    input  logic              clear_i,
    output logic [OUTS-1:0]   dec_o,
    output logic              carry_o
);
    logic [OUTS-1:0] raw;

    // Two-bit window per count: fill phase then drain phase
    for (genvar k = 0; k < OUTS; k++) begin : g_win
        if (k == 0) begin : g_zero
            assign raw[k] = ~state_i[STAGES-1] & ~state_i[0];
        end else if (k < STAGES) begin : g_fill
            assign raw[k] = state_i[k-1] & ~state_i[k];
        end else if (k == STAGES) begin : g_full
            assign raw[k] = state_i[STAGES-1] & state_i[0];
        end else begin : g_drain
            assign raw[k] = ~state_i[k-STAGES-1] & state_i[k-STAGES];
        end
    end

    // Output forcing under clear
    always_comb begin
        if (clear_i) begin
            dec_o   = OUTS'(1);
            carry_o = 1'b1;
        end else begin
            dec_o   = raw;
            carry_o = ~state_i[STAGES-1];
        end
    end

    // R5
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(state_i[STAGES-1:1] ^ state_i[STAGES-2:0]) <= 1) |-> ($countones(dec_o) == 1));

    // R6
    carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && $countones(dec_o) == 1) |-> (carry_o == (dec_o[STAGES-1:0] != '0)));
endmodule

// File: rtl/johnson_decade_div.sv
// Module: top of the Johnson decade divider. Synchronizes the control
// levels, detects count steps, runs the twisted ring and decodes it.
// Assumes: one system clock; rst_n is synchronous and active low.
module johnson_decade_div
    import jdc_pkg::*;
#(
    parameter int STAGES = JDC_STAGES,
    parameter int OUTS   = 2 * STAGES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnt_clk_i,
    input  logic            cnt_inhibit_i,
    input  logic            clear_i,
    output logic [OUTS-1:0] dec_o,
    output logic            carry_o
);
    jdc_ctl_t          ctl_async;
    jdc_ctl_t          ctl_sync;
    logic              step;
    logic [STAGES-1:0] state;

    assign ctl_async = '{cnt_clk: cnt_clk_i, inhibit: cnt_inhibit_i, clear: clear_i};

    jdc_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_async),
        .sync_o  (ctl_sync)
    );

    jdc_step_detect u_step (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_clk_s_i (ctl_sync.cnt_clk),
        .inhibit_s_i (ctl_sync.inhibit),
        .clear_s_i   (ctl_sync.clear),
        .step_o      (step)
    );

    jdc_ring #(.STAGES(STAGES)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .clr_i   (ctl_sync.clear),
        .state_o (state)
    );

    jdc_decode #(.STAGES(STAGES), .OUTS(OUTS)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .clear_i (clear_i),
        .dec_o   (dec_o),
        .carry_o (carry_o)
    );

    // R7
    clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |-> (dec_o == OUTS'(1) && carry_o));

    // R1
    reset_exit_chk: assert property (@(posedge clk)
        !rst_n |=> (dec_o == OUTS'(1) || clear_i || ctl_sync.clear || !rst_n));
endmodule

// File: tb/tb_johnson_decade_div.sv
module tb_johnson_decade_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_clk_i = 1'b0;
    logic       cnt_inhibit_i = 1'b0;
    logic       clear_i = 1'b0;
    logic [9:0] dec_o;
    logic       carry_o;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    johnson_decade_div dut (
        .clk(clk), .rst_n(rst_n), .cnt_clk_i(cnt_clk_i),
        .cnt_inhibit_i(cnt_inhibit_i), .clear_i(clear_i),
        .dec_o(dec_o), .carry_o(carry_o)
    );

    function automatic logic [4:0] code_of(input int k);
        if (k < 5) return 5'((1 << k) - 1);
        return 5'h1f ^ 5'((1 << (k - 5)) - 1);
    endfunction

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(input string tag);
        logic [9:0] e_dec;
        logic       e_car;
        e_dec = 10'(1 << exp_cnt);
        e_car = (exp_cnt < 5);
        checks++;
        if (dec_o !== e_dec || carry_o !== e_car) begin
            errors++;
            $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b",
                     tag, dec_o, carry_o, e_dec, e_car);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
        check_out("R1 reset state");

        // R2 R5 R6: 25 steps by count clock rise, fall holds (R4)
        for (int i = 0; i < 25; i++) begin
            cnt_clk_i = 1'b1; settle();
            exp_cnt = (exp_cnt + 1) % 10;
            check_out("R2 R5 R6 rise step");
            cnt_clk_i = 1'b0; settle();
            check_out("R4 fall no step");
        end

        // R4: inhibit held high blocks clock pulses
        cnt_inhibit_i = 1'b1; settle();
        for (int i = 0; i < 3; i++) begin
            cnt_clk_i = 1'b1; settle();
            cnt_clk_i = 1'b0; settle();
        end
        check_out("R4 inhibit high");

        // R3: inhibit falls while clock high
        cnt_clk_i = 1'b1; settle();
        check_out("R4 clock rise under inhibit");
        cnt_inhibit_i = 1'b0; settle();
        exp_cnt = (exp_cnt + 1) % 10;
        check_out("R3 inhibit fall step");
        cnt_inhibit_i = 1'b1; settle();
        check_out("R4 inhibit rise no step");
        cnt_clk_i = 1'b0; settle();
        cnt_inhibit_i = 1'b0; settle();
        check_out("R4 inhibit fall with clock low");

        // R9: level held high counts once
        cnt_clk_i = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        exp_cnt = (exp_cnt + 1) % 10;
        check_out("R9 held level single step");
        cnt_clk_i = 1'b0; settle();

        // R7: clear forces count 0 immediately and ignores the clock
        while (exp_cnt != 7) begin
            cnt_clk_i = 1'b1; settle();
            cnt_clk_i = 1'b0; settle();
            exp_cnt = (exp_cnt + 1) % 10;
        end
        check_out("R6 count 7 before clear");
        clear_i = 1'b1;
        #1;
        exp_cnt = 0;
        check_out("R7 clear combinational");
        @(negedge clk);
        cnt_clk_i = 1'b1; settle();
        check_out("R7 clock ignored during clear");
        clear_i = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check_out("R7 no step on clear release");
        cnt_clk_i = 1'b0; settle();
        cnt_clk_i = 1'b1; settle();
        exp_cnt = 1;
        check_out("R7 first step after clear");
        cnt_clk_i = 1'b0; settle();

        // R8: every register code followed by one step
        for (int c = 0; c < 32; c++) begin
            int nxt;
            nxt = 0;
            for (int k = 0; k < 10; k++)
                if (code_of(k) == 5'(c)) nxt = (k + 1) % 10;
            @(negedge clk);
            force dut.u_ring.state_q = 5'(c);
            #1;
            release dut.u_ring.state_q;
            @(negedge clk);
            cnt_clk_i = 1'b1; settle();
            exp_cnt = nxt;
            check_out("R8 code recovery");
            cnt_clk_i = 1'b0; settle();
        end

        // R1: reset mid-count
        cnt_clk_i = 1'b1; settle();
        cnt_clk_i = 1'b0; settle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_cnt = 0;
        check_out("R1 reset mid-count");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule